// File: doc/BRIEF.md
# Full/Empty Tagged Word Memory

This block is a small word-addressed store in which every word carries one tag bit saying whether the word currently holds an unconsumed value (full) or not (empty). Producers and consumers use it to hand single words to each other without any lock. A producer uses a synchronizing store. It lands only on an empty word and leaves the word full. A consumer uses a synchronizing load. It succeeds only on a full word, hands back the value and leaves the word empty. If the tag does not allow the access, the memory answers with a retry status and changes nothing. The requester then tries again later.

Plain loads and stores are also accepted. They move data and never look at or alter the tag, which suits setup and debug traffic. A separate tag-force input sets the tag of one chosen address to full or to empty, so software can prepare the memory before producer/consumer traffic starts. Each request is served in one clock cycle. The tag test, the data access and the tag update take effect together at one clock edge. The registered response appears on the following cycle.

Top module: `fe_word_mem`

## Requirements
- R1: After reset every tag is empty, every word reads as zero and `rsp_valid` is low.
- R2: A synchronizing store (`req_op`=3) to an empty word writes `req_wdata`, sets the tag to full and responds with status 0 (done).
- R3: A synchronizing store to a full word responds with status 1 (retry) and leaves both the word's data and its tag unchanged, so an unconsumed value is never overwritten.
- R4: A synchronizing load (`req_op`=2) from a full word returns the stored data on `rsp_rdata`, clears the tag to empty and responds with status 0.
- R5: A synchronizing load from an empty word responds with status 1, returns zero on `rsp_rdata` and changes neither data nor tag.
- R6: A plain load (`req_op`=0) always responds with status 0 and returns the stored data, whatever the tag, and leaves the tag as it was.
- R7: A plain store (`req_op`=1) always writes the data with status 0 and leaves the tag as it was, whether full or empty.
- R8: Every request accepted at a clock edge yields exactly one response with `rsp_valid` high in the next cycle. The response's `rsp_tag` reports the tag the word had before the access (1 = full). A cycle without a request yields no response.
- R9: With `frc_valid` high, the tag of `frc_addr` becomes `frc_full` (1 = full, 0 = empty) at the next edge and the word's data is untouched.
- R10: When a force and a request hit the same address in the same cycle, the request is judged against the tag from before that cycle and makes its data change. The tag then ends at the forced value.
- R11: An access or force to one address changes no other address, including the lowest and highest addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 2 | 0 plain load, 1 plain store, 2 synchronizing load, 3 synchronizing store |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Store data |
| frc_valid | input | 1 | Force the tag of `frc_addr` this cycle |
| frc_addr | input | ADDR_W | Address whose tag is forced |
| frc_full | input | 1 | Forced tag value, 1 full, 0 empty |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_status | output | 1 | 0 done, 1 retry |
| rsp_tag | output | 1 | Tag of the word before the access |
| rsp_rdata | output | DATA_W | Load data on a successful load, else zero |

## Verification
The two functions that can meet in one cycle are a synchronizing access and a tag force aimed at the same word. The bench provokes this by presenting both on the same cycle. In one case a synchronizing store to an empty word comes with a force to empty. In the other a synchronizing load from an empty word comes with a force to full. The results are judged from the response status and from later plain loads. The first case must report done, store its data and end empty. The second must report retry and end full.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN_LD = 2'd0,
        OP_PLAIN_ST = 2'd1,
        OP_SYNC_LD  = 2'd2,
        OP_SYNC_ST  = 2'd3
    } fe_op_e;

    typedef enum logic {
        ST_DONE  = 1'b0,
        ST_RETRY = 1'b1
    } fe_status_e;

    localparam logic TAG_EMPTY = 1'b0;
    localparam logic TAG_FULL  = 1'b1;

endpackage

// File: rtl/fe_tag_array.sv
module fe_tag_array #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_val,
    input  logic              frc_en,
    input  logic [ADDR_W-1:0] frc_addr,
    input  logic              frc_val,
    output logic [DEPTH-1:0]  tags
);
    import fe_mem_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0] bits;
    } tag_state_t;

    tag_state_t tag_d, tag_q;
    logic [DEPTH-1:0] nxt;

    // Per-word next tag: a force outranks the access update on the same word.
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign nxt[i] = (frc_en && frc_addr == ADDR_W'(i)) ? frc_val :
                        (upd_en && upd_addr == ADDR_W'(i)) ? upd_val :
                        tag_q.bits[i];
    end

    always_comb begin
        tag_d      = tag_q;
        tag_d.bits = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q.bits <= {DEPTH{TAG_EMPTY}};
        end else begin
            tag_q <= tag_d;
        end
    end

    assign tags = tag_q.bits;

endmodule

// File: rtl/fe_data_array.sv
module fe_data_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] word;
    } data_state_t;

    data_state_t dat_d, dat_q;

    always_comb begin
        dat_d = dat_q;
        if (we) begin
            dat_d.word[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
        end else begin
            dat_q <= dat_d;
        end
    end

    // Read is combinational so the tag test and the data use share one cycle.
    assign rdata = dat_q.word[addr];

endmodule

// File: rtl/fe_access_ctrl.sv
module fe_access_ctrl #(
    parameter int DATA_W = 16
) (
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              cur_tag,
    input  logic [DATA_W-1:0] cur_data,
    output logic              data_we,
    output logic              tag_we,
    output logic              tag_val,
    output logic              status,
    output logic [DATA_W-1:0] ld_data
);
    import fe_mem_pkg::*;

    fe_op_e op;
    assign op = fe_op_e'(req_op);

    always_comb begin
        data_we = 1'b0;
        tag_we  = 1'b0;
        tag_val = cur_tag;
        status  = ST_DONE;
        ld_data = '0;
        if (req_valid) begin
            unique case (op)
                OP_PLAIN_LD: begin
                    ld_data = cur_data;
                end
                OP_PLAIN_ST: begin
                    data_we = 1'b1;
                end
                OP_SYNC_LD: begin
                    if (cur_tag == TAG_FULL) begin
                        ld_data = cur_data;
                        tag_we  = 1'b1;
                        tag_val = TAG_EMPTY;
                    end else begin
                        status = ST_RETRY;
                    end
                end
                OP_SYNC_ST: begin
                    if (cur_tag == TAG_EMPTY) begin
                        data_we = 1'b1;
                        tag_we  = 1'b1;
                        tag_val = TAG_FULL;
                    end else begin
                        status = ST_RETRY;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fe_rsp_reg.sv
module fe_rsp_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_status,
    input  logic              in_tag,
    input  logic [DATA_W-1:0] in_rdata,
    output logic              out_valid,
    output logic              out_status,
    output logic              out_tag,
    output logic [DATA_W-1:0] out_rdata
);

    typedef struct packed {
        logic              valid;
        logic              status;
        logic              tag;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d        = '0;
        rsp_d.valid  = in_valid;
        if (in_valid) begin
            rsp_d.status = in_status;
            rsp_d.tag    = in_tag;
            rsp_d.rdata  = in_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign out_valid  = rsp_q.valid;
    assign out_status = rsp_q.status;
    assign out_tag    = rsp_q.tag;
    assign out_rdata  = rsp_q.rdata;

endmodule

// File: rtl/fe_word_mem.sv
module fe_word_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              frc_valid,
    input  logic [ADDR_W-1:0] frc_addr,
    input  logic              frc_full,
    output logic              rsp_valid,
    output logic              rsp_status,
    output logic              rsp_tag,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0]  tag_vec;
    logic              cur_tag;
    logic [DATA_W-1:0] cur_data;
    logic              data_we;
    logic              tag_we;
    logic              tag_val;
    logic              acc_status;
    logic [DATA_W-1:0] ld_data;

    assign cur_tag = tag_vec[req_addr];

    fe_tag_array #(.ADDR_W(ADDR_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (tag_we),
        .upd_addr (req_addr),
        .upd_val  (tag_val),
        .frc_en   (frc_valid),
        .frc_addr (frc_addr),
        .frc_val  (frc_full),
        .tags     (tag_vec)
    );

    fe_data_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (data_we),
        .addr  (req_addr),
        .wdata (req_wdata),
        .rdata (cur_data)
    );

    fe_access_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .req_valid (req_valid),
        .req_op    (req_op),
        .cur_tag   (cur_tag),
        .cur_data  (cur_data),
        .data_we   (data_we),
        .tag_we    (tag_we),
        .tag_val   (tag_val),
        .status    (acc_status),
        .ld_data   (ld_data)
    );

    fe_rsp_reg #(.DATA_W(DATA_W)) u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (req_valid),
        .in_status  (acc_status),
        .in_tag     (cur_tag),
        .in_rdata   (ld_data),
        .out_valid  (rsp_valid),
        .out_status (rsp_status),
        .out_tag    (rsp_tag),
        .out_rdata  (rsp_rdata)
    );

endmodule

// File: rtl/fe_word_mem_chk.sv
module fe_word_mem_chk #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              frc_valid,
    input logic [ADDR_W-1:0] frc_addr,
    input logic              rsp_valid,
    input logic              rsp_status,
    input logic              rsp_tag,
    input logic [DEPTH-1:0]  tag_vec
);

    logic prev_rst_n;
    always_ff @(posedge clk) begin
        prev_rst_n <= rst_n;
        if (rst_n && !prev_rst_n) begin
            p_tags_empty_r1: assert (tag_vec == '0);
        end
    end

    p_rsp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_idle_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_plain_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op[1]) |=> !rsp_status);

    p_sync_ld_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd2) |=> (rsp_status == !rsp_tag));

    p_sync_st_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3) |=> (rsp_status == rsp_tag));

    p_sync_st_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3 && !tag_vec[req_addr] && !frc_valid)
        |=> tag_vec[$past(req_addr)]);

    p_retry_keeps_tags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[1] && (tag_vec[req_addr] == req_op[0]) && !frc_valid)
        |=> $stable(tag_vec));

    p_force_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_valid && req_valid && frc_addr == req_addr) |=> rsp_valid);

endmodule

bind fe_word_mem fe_word_mem_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .frc_valid  (frc_valid),
    .frc_addr   (frc_addr),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_tag    (rsp_tag),
    .tag_vec    (tag_vec)
);

// File: tb/test_fe_word_mem.sv
module test_fe_word_mem;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              frc_valid = 1'b0;
    logic [ADDR_W-1:0] frc_addr = '0;
    logic              frc_full = 1'b0;
    logic              rsp_valid;
    logic              rsp_status;
    logic              rsp_tag;
    logic [DATA_W-1:0] rsp_rdata;

    int checks = 0;
    int failures = 0;
    logic              r_valid, r_status, r_tag;
    logic [DATA_W-1:0] r_data;

    always #2 clk = ~clk;

    fe_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fe_word_mem (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .frc_valid(frc_valid), .frc_addr(frc_addr), .frc_full(frc_full),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_tag(rsp_tag), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // One request (optionally with a force); response sampled on the next negedge.
    task automatic access(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input logic fv,
                          input logic [ADDR_W-1:0] fa, input logic ff);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        frc_valid = fv; frc_addr = fa; frc_full = ff;
        @(negedge clk);
        req_valid = 1'b0; frc_valid = 1'b0;
        r_valid = rsp_valid; r_status = rsp_status; r_tag = rsp_tag; r_data = rsp_rdata;
    endtask

    task automatic force_tag(input logic [ADDR_W-1:0] a, input logic full);
        @(negedge clk);
        frc_valid = 1'b1; frc_addr = a; frc_full = full;
        @(negedge clk);
        frc_valid = 1'b0;
        chk("R9 no response for force alone", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic peek(input string tagname, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] exp_d, input logic exp_t);
        access(2'd0, a, '0, 1'b0, '0, 1'b0);
        chk({tagname, " data"}, {16'd0, r_data}, {16'd0, exp_d});
        chk({tagname, " tag"}, {31'd0, r_tag}, {31'd0, exp_t});
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid low after reset", {31'd0, rsp_valid}, 32'd0);
        peek("R1 word 0", 4'd0, 16'h0000, 1'b0);
        peek("R1 word 7", 4'd7, 16'h0000, 1'b0);
        peek("R1 word 15", 4'd15, 16'h0000, 1'b0);
    endtask

    task automatic t_sync_store();
        access(2'd3, 4'd3, 16'hA5A5, 1'b0, '0, 1'b0);
        chk("R2 sync store empty status", {31'd0, r_status}, 32'd0);
        chk("R8 sync store prior tag", {31'd0, r_tag}, 32'd0);
        peek("R2 after sync store", 4'd3, 16'hA5A5, 1'b1);
        access(2'd3, 4'd3, 16'h1234, 1'b0, '0, 1'b0);
        chk("R3 sync store full retry", {31'd0, r_status}, 32'd1);
        peek("R3 full word kept", 4'd3, 16'hA5A5, 1'b1);
    endtask

    task automatic t_sync_load();
        access(2'd2, 4'd3, '0, 1'b0, '0, 1'b0);
        chk("R4 sync load full status", {31'd0, r_status}, 32'd0);
        chk("R4 sync load data", {16'd0, r_data}, 32'h0000A5A5);
        peek("R4 tag cleared", 4'd3, 16'hA5A5, 1'b0);
        access(2'd2, 4'd3, '0, 1'b0, '0, 1'b0);
        chk("R5 sync load empty retry", {31'd0, r_status}, 32'd1);
        chk("R5 retry data zero", {16'd0, r_data}, 32'd0);
        peek("R5 word unchanged", 4'd3, 16'hA5A5, 1'b0);
    endtask

    task automatic t_plain();
        access(2'd1, 4'd5, 16'h0F0F, 1'b0, '0, 1'b0);
        chk("R7 plain store empty status", {31'd0, r_status}, 32'd0);
        peek("R7 plain store keeps empty", 4'd5, 16'h0F0F, 1'b0);
        access(2'd3, 4'd5, 16'h5555, 1'b0, '0, 1'b0);
        access(2'd1, 4'd5, 16'h7777, 1'b0, '0, 1'b0);
        chk("R7 plain store full status", {31'd0, r_status}, 32'd0);
        peek("R6 plain load full word", 4'd5, 16'h7777, 1'b1);
        access(2'd0, 4'd5, '0, 1'b0, '0, 1'b0);
        chk("R6 plain load status", {31'd0, r_status}, 32'd0);
        chk("R6 repeated load keeps full", {31'd0, r_tag}, 32'd1);
    endtask

    task automatic t_force();
        force_tag(4'd9, 1'b1);
        peek("R9 force full", 4'd9, 16'h0000, 1'b1);
        force_tag(4'd5, 1'b0);
        peek("R9 force empty", 4'd5, 16'h7777, 1'b0);
    endtask

    task automatic t_same_cycle();
        access(2'd3, 4'd3, 16'hBEEF, 1'b1, 4'd3, 1'b0);
        chk("R10 store with force empty status", {31'd0, r_status}, 32'd0);
        peek("R10 store data kept tag forced", 4'd3, 16'hBEEF, 1'b0);
        access(2'd2, 4'd3, '0, 1'b1, 4'd3, 1'b1);
        chk("R10 load judged on prior tag", {31'd0, r_status}, 32'd1);
        chk("R10 load retry data", {16'd0, r_data}, 32'd0);
        peek("R10 tag forced full", 4'd3, 16'hBEEF, 1'b1);
    endtask

    task automatic t_indep();
        access(2'd3, 4'd15, 16'hCAFE, 1'b0, '0, 1'b0);
        chk("R11 top word store", {31'd0, r_status}, 32'd0);
        peek("R11 word 0 untouched", 4'd0, 16'h0000, 1'b0);
        peek("R11 word 14 untouched", 4'd14, 16'h0000, 1'b0);
        peek("R11 word 15 filled", 4'd15, 16'hCAFE, 1'b1);
        force_tag(4'd0, 1'b1);
        peek("R11 word 15 after force of 0", 4'd15, 16'hCAFE, 1'b1);
    endtask

    task automatic t_timing();
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd2; req_addr = 4'd15; req_wdata = '0;
        @(negedge clk);
        chk("R8 first back-to-back valid", {31'd0, rsp_valid}, 32'd1);
        chk("R8 first back-to-back data", {16'd0, rsp_rdata}, 32'h0000CAFE);
        req_op = 2'd2; req_addr = 4'd15;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 second back-to-back valid", {31'd0, rsp_valid}, 32'd1);
        chk("R8 second sees emptied word", {31'd0, rsp_status}, 32'd1);
        chk("R8 second prior tag", {31'd0, rsp_tag}, 32'd0);
        @(negedge clk);
        chk("R8 idle cycle no response", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sync_store();
        t_sync_load();
        t_plain();
        t_force();
        t_same_cycle();
        t_indep();
        t_timing();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule